// File: doc/BRIEF.md
# I2C Master Command-Stream Sequencer

This block is an I2C bus master that runs whole transactions from a queue of 10-bit command words. Software, or another engine, pushes words into a 16-entry transmit queue. Each word holds one byte plus two control flags: one asks for a start condition before the byte, the other asks for a stop condition at the end of the transfer that the word closes. A word that carries the start flag is an address word. For a read, the address word is followed by a count word that gives the number of bytes to fetch. The fetched bytes land in a 16-entry receive queue. Once the words are queued, a complete write, read or combined write-then-read transaction runs with no further writes.

The bus is driven through open-drain enables: an enable of 1 pulls the line low. Every SCL high phase and every SCL low phase lasts `DIV` system clocks. The block reports the following:
- how full each queue is
- whether it owns the bus
- a pulse for a transmit error (NACK on an address or written byte, or the final byte of a read)
- a pulse when the bus becomes free after a stop
- a level that shows the receive queue has reached a programmable threshold

Top module: `i2c_cmd_master`

## Requirements
- R1: A command word is laid out as bits 7:0 = byte, bit 8 = start flag, bit 9 = stop flag. In a start-flagged word, bits 7:1 are the 7-bit target address and bit 0 is the direction (1 = read, 0 = write).
- R2: In a write, the block sends a start, then the address byte, then each following data word's byte MSB first. It samples the target's ACK on the ninth clock of each byte and issues a stop after the word that carries the stop flag.
- R3: In a read, bits 7:0 of the word after the address word give the byte count. Each received byte is pushed into the receive queue. The master ACKs every byte except the last, which it NACKs. It pulses `tx_err_o` once at the last byte and issues a stop if the count word's stop flag is set.
- R4: An address word that carries both flags performs an address-only write, followed directly by a stop.
- R5: A start-flagged word reached while the block still owns the bus produces a repeated start, with no stop in between.
- R6: Each queue holds 16 entries. The occupancy outputs give the entry count minus one, or 0 when the queue is empty. A push into a full queue is dropped.
- R7: `rx_thr_o` is high while the receive queue holds at least `rx_lvl_i + 1` entries.
- R8: A NACK on an address byte or on a written byte pulses `tx_err_o`, and the block then issues a stop.
- R9: `busy_o` rises when a start begins. `bnb_o` pulses for one cycle when a stop completes, and `busy_o` falls in that same cycle.
- R10: `tx_flush_i` empties the transmit queue. While `en_i` is low, no word is taken from the queue.
- R11: If a read's count word has not been queued when the address byte is acknowledged, SCL is held low until the count word arrives.
- R12: Each SCL high phase of a data bit lasts exactly `DIV` clocks, and SDA does not change while SCL is released during a data bit.
- R13: A word without a start flag that is reached while the block does not own the bus is discarded and pulses `tx_err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Device enable; when low, no commands are taken from the queue |
| tx_flush_i | input | 1 | Empties the transmit queue |
| tx_wr_i | input | 1 | Pushes `tx_word_i` into the transmit queue |
| tx_word_i | input | 10 | Command word: stop flag, start flag, byte |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_occ_o | output | AW | Transmit entries minus one |
| rx_rd_i | input | 1 | Pops the head of the receive queue |
| rx_data_o | output | 8 | Head of the receive queue |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_occ_o | output | AW | Receive entries minus one |
| rx_lvl_i | input | AW | Zero-based receive threshold |
| rx_thr_o | output | 1 | Receive queue at or above threshold + 1 |
| busy_o | output | 1 | Block owns the bus |
| tx_err_o | output | 1 | Pulse: NACK, final read byte, or discarded word |
| bnb_o | output | 1 | Pulse: stop completed, bus free |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| sda_i | input | 1 | SDA line level |

## Verification
Two situations are the hardest to reach from the ports. The first is the stall in the middle of a read: the address byte has been acknowledged but the count word is not yet queued. The bench queues only the read address word, lets hundreds of cycles pass while it watches SCL stay low with no stop, and then supplies the count word. The second is a NACK on a written data byte, which leaves the rest of the message in the queue. The bench model of the target refuses one chosen byte, so the stop that follows and the discard of the stray leftover word can both be seen as `tx_err_o` pulses. A repeated start is reached by queuing a write without a stop ahead of a read.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int WORD_W    = 10;
  localparam int START_BIT = 8;
  localparam int STOP_BIT  = 9;

  typedef enum logic [1:0] {L_START, L_STOP, L_BYTE} line_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_CNT, S_RD, S_WR, S_STOP
  } seq_state_e;
endpackage

// File: rtl/i2c_seq_fifo.sv
module i2c_seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rd_i,
  output logic [W-1:0]  rdata_o,
  output logic [AW:0]   count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_wr, do_rd;

  assign full_o  = (cnt == (AW+1)'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_wr   = wr_i && !full_o;
  assign do_rd   = rd_i && !empty_o;
  assign rdata_o = mem[rp];
  assign count_o = cnt;

  always_ff @(posedge clk_i) if (do_wr) mem[wp] <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (clr_i) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (do_wr && !do_rd) cnt <= cnt + 1'b1;
      else if (do_rd && !do_wr) cnt <= cnt - 1'b1;
    end
  end

  p_full_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && !clr_i && full_o) |=> (count_o == $past(count_o)));
  p_empty_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && empty_o) |=> empty_o);
endmodule

// File: rtl/i2c_line_engine.sv
module i2c_line_engine
  import i2c_seq_pkg::*;
#(
  parameter int DIV = 4,
  localparam int TW = $clog2(DIV + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      go_i,
  input  line_cmd_e cmd_i,
  input  logic [8:0] bits_i,
  input  logic      sda_i,
  output logic      done_o,
  output logic [8:0] bits_o,
  output logic      own_o,
  output logic      scl_oe_o,
  output logic      sda_oe_o
);
  typedef enum logic [1:0] {E_IDLE, E_START, E_STOP, E_BIT} eng_state_e;

  eng_state_e    st;
  logic [1:0]    ph;
  logic [TW-1:0] tmr;
  logic [3:0]    bitn;
  logic [8:0]    sh;
  logic          own, done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= E_IDLE; ph <= '0; tmr <= '0; bitn <= '0;
      sh <= '0; own <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == E_IDLE) begin
        if (go_i) begin
          tmr <= TW'(DIV - 1);
          unique case (cmd_i)
            L_START: begin st <= E_START; ph <= own ? 2'd0 : 2'd1; own <= 1'b1; end
            L_STOP:  begin st <= E_STOP;  ph <= 2'd0; end
            default: begin st <= E_BIT;   ph <= 2'd0; sh <= bits_i; bitn <= '0; end
          endcase
        end
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end else begin
        tmr <= TW'(DIV - 1);
        unique case (st)
          E_START: if (ph == 2'd3) begin st <= E_IDLE; done <= 1'b1; end
                   else ph <= ph + 1'b1;
          E_STOP:  if (ph == 2'd2) begin st <= E_IDLE; own <= 1'b0; done <= 1'b1; end
                   else ph <= ph + 1'b1;
          default: if (ph == 2'd0) ph <= 2'd1;
                   else begin
                     sh <= {sh[7:0], sda_i};  // sample at end of SCL high
                     if (bitn == 4'd8) begin st <= E_IDLE; done <= 1'b1; end
                     else begin bitn <= bitn + 1'b1; ph <= 2'd0; end
                   end
        endcase
      end
    end
  end

  always_comb begin
    scl_oe_o = own;
    sda_oe_o = 1'b0;
    unique case (st)
      E_START: unique case (ph)
                 2'd0:    begin scl_oe_o = 1'b1; sda_oe_o = 1'b0; end
                 2'd1:    begin scl_oe_o = 1'b0; sda_oe_o = 1'b0; end
                 2'd2:    begin scl_oe_o = 1'b0; sda_oe_o = 1'b1; end
                 default: begin scl_oe_o = 1'b1; sda_oe_o = 1'b1; end
               endcase
      E_STOP:  unique case (ph)
                 2'd0:    begin scl_oe_o = 1'b1; sda_oe_o = 1'b1; end
                 2'd1:    begin scl_oe_o = 1'b0; sda_oe_o = 1'b1; end
                 default: begin scl_oe_o = 1'b0; sda_oe_o = 1'b0; end
               endcase
      E_BIT:   begin scl_oe_o = (ph == 2'd0); sda_oe_o = ~sh[8]; end
      default: ;
    endcase
  end

  assign done_o = done;
  assign bits_o = sh;
  assign own_o  = own;

  p_sda_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == E_BIT && $past(st == E_BIT) && !scl_oe_o && !$past(scl_oe_o))
      |-> $stable(sda_oe_o));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_seq_pkg::*;
#(
  parameter int DIV        = 4,
  parameter int FIFO_DEPTH = 16,
  localparam int AW        = $clog2(FIFO_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tx_flush_i,
  input  logic              tx_wr_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              tx_full_o,
  output logic              tx_empty_o,
  output logic [AW-1:0]     tx_occ_o,
  input  logic              rx_rd_i,
  output logic [7:0]        rx_data_o,
  output logic              rx_empty_o,
  output logic [AW-1:0]     rx_occ_o,
  input  logic [AW-1:0]     rx_lvl_i,
  output logic              rx_thr_o,
  output logic              busy_o,
  output logic              tx_err_o,
  output logic              bnb_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  logic [WORD_W-1:0] tx_rdata;
  logic [AW:0]       tx_cnt, rx_cnt;
  logic              tx_pop, rx_push, rx_full;

  seq_state_e st;
  logic       wait_q, stop_q, err_q;
  logic [7:0] byte_q, left;

  logic       eng_go, eng_done, eng_own;
  line_cmd_e  eng_cmd;
  logic [8:0] eng_bits, eng_rx;

  i2c_seq_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(tx_flush_i), .wr_i(tx_wr_i), .wdata_i(tx_word_i),
    .rd_i(tx_pop), .rdata_o(tx_rdata), .count_o(tx_cnt),
    .full_o(tx_full_o), .empty_o(tx_empty_o));

  i2c_seq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(1'b0), .wr_i(rx_push), .wdata_i(eng_rx[8:1]),
    .rd_i(rx_rd_i), .rdata_o(rx_data_o), .count_o(rx_cnt),
    .full_o(rx_full), .empty_o(rx_empty_o));

  i2c_line_engine #(.DIV(DIV)) u_eng (
    .clk_i, .rst_ni, .go_i(eng_go), .cmd_i(eng_cmd), .bits_i(eng_bits),
    .sda_i, .done_o(eng_done), .bits_o(eng_rx), .own_o(eng_own),
    .scl_oe_o, .sda_oe_o);

  assign tx_occ_o = tx_empty_o ? '0 : AW'(tx_cnt - 1'b1);
  assign rx_occ_o = rx_empty_o ? '0 : AW'(rx_cnt - 1'b1);
  assign rx_thr_o = rx_cnt > {1'b0, rx_lvl_i};

  assign tx_pop  = !tx_empty_o && ((st == S_IDLE && en_i) || st == S_CNT);
  assign rx_push = eng_done && st == S_RD;
  assign eng_go  = !wait_q && (st == S_START || st == S_ADDR || st == S_WR ||
                               st == S_STOP || (st == S_RD && !rx_full));
  assign eng_cmd  = (st == S_START) ? L_START : (st == S_STOP) ? L_STOP : L_BYTE;
  // read: ack slot 0 drives ACK, 1 releases for NACK on the final byte
  assign eng_bits = (st == S_RD) ? {8'hFF, left == 8'd1} : {byte_q, 1'b1};

  assign busy_o   = eng_own;
  assign bnb_o    = eng_done && st == S_STOP;
  assign tx_err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; wait_q <= 1'b0; stop_q <= 1'b0; err_q <= 1'b0;
      byte_q <= '0; left <= '0;
    end else begin
      err_q <= 1'b0;
      if (eng_done) wait_q <= 1'b0;
      else if (eng_go) wait_q <= 1'b1;
      unique case (st)
        S_IDLE: if (tx_pop) begin
          byte_q <= tx_rdata[7:0];
          stop_q <= tx_rdata[STOP_BIT];
          if (tx_rdata[START_BIT]) st <= S_START;
          else if (eng_own)        st <= S_WR;
          else                     err_q <= 1'b1;  // stray data word
        end
        S_START: if (eng_done) st <= S_ADDR;
        S_ADDR: if (eng_done) begin
          if (eng_rx[0])     begin err_q <= 1'b1; st <= S_STOP; end
          else if (byte_q[0]) st <= S_CNT;
          else               st <= stop_q ? S_STOP : S_IDLE;
        end
        S_CNT: if (tx_pop) begin
          left   <= tx_rdata[7:0];
          stop_q <= tx_rdata[STOP_BIT];
          if (tx_rdata[7:0] == 8'd0) st <= tx_rdata[STOP_BIT] ? S_STOP : S_IDLE;
          else                       st <= S_RD;
        end
        S_RD: if (eng_done) begin
          left <= left - 1'b1;
          if (left == 8'd1) begin err_q <= 1'b1; st <= stop_q ? S_STOP : S_IDLE; end
        end
        S_WR: if (eng_done) begin
          if (eng_rx[0]) begin err_q <= 1'b1; st <= S_STOP; end
          else           st <= stop_q ? S_STOP : S_IDLE;
        end
        default: if (eng_done) st <= S_IDLE;
      endcase
    end
  end

  p_bnb_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnb_o |-> !busy_o);
  p_busy_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> bnb_o);
  p_cnt_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_CNT) |-> (scl_oe_o && busy_o));
  p_rx_no_push_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push |-> !rx_full);
endmodule

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb;
  localparam int DIV = 4;
  localparam logic [6:0] SLV = 7'h50;
  // [31] rd, [30:24] addr, [23:16] len, [15:8] seed, [1:0] expected tx_err pulses
  localparam logic [31:0] VEC [5] = '{
    {1'b0, 7'h50, 8'd3, 8'h11, 6'd0, 2'd0},
    {1'b1, 7'h50, 8'd4, 8'h00, 6'd0, 2'd1},
    {1'b0, 7'h50, 8'd0, 8'h00, 6'd0, 2'd0},
    {1'b0, 7'h23, 8'd0, 8'h00, 6'd0, 2'd1},
    {1'b1, 7'h50, 8'd1, 8'h00, 6'd0, 2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, flush = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
  logic [9:0] tx_word = '0;
  logic [3:0] rx_lvl = 4'd15;
  logic tx_full, tx_empty, rx_empty, rx_thr, busy, tx_err, bnb, scl_oe, sda_oe;
  logic [3:0] tx_occ, rx_occ;
  logic [7:0] rx_data;
  logic scl, sda, slv_low;

  int checks = 0, errors = 0;
  int err_cnt = 0, bnb_cnt = 0;
  int start_cnt, rs_cnt, stop_cnt, wr_cnt, nack_at, bitcnt, rd_idx, hi_run, last_hi;
  logic [7:0] wr_log [32];
  logic [7:0] shreg, rd_byte;
  bit in_xfer, is_addr, rd_mode, addr_ok, mack;
  logic p_scl, p_sda;

  always #10 clk = ~clk;

  assign scl = ~scl_oe;
  assign sda = ~(sda_oe | slv_low);

  i2c_cmd_master #(.DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tx_flush_i(flush),
    .tx_wr_i(tx_wr), .tx_word_i(tx_word), .tx_full_o(tx_full),
    .tx_empty_o(tx_empty), .tx_occ_o(tx_occ), .rx_rd_i(rx_rd),
    .rx_data_o(rx_data), .rx_empty_o(rx_empty), .rx_occ_o(rx_occ),
    .rx_lvl_i(rx_lvl), .rx_thr_o(rx_thr), .busy_o(busy), .tx_err_o(tx_err),
    .bnb_o(bnb), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda));

  // target model, sampled away from the DUT's active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      slv_low = 1'b0; start_cnt = 0; rs_cnt = 0; stop_cnt = 0; wr_cnt = 0;
      nack_at = 99; bitcnt = 0; rd_idx = 0; hi_run = 0; last_hi = 0;
      in_xfer = 0; is_addr = 0; rd_mode = 0; addr_ok = 0; mack = 0;
      shreg = '0; rd_byte = '0; p_scl = 1'b1; p_sda = 1'b1;
    end else begin
      if (tx_err) err_cnt++;
      if (bnb) bnb_cnt++;
      if (scl && p_scl && p_sda && !sda) begin
        start_cnt++;
        if (in_xfer) rs_cnt++;
        in_xfer = 1; bitcnt = 0; is_addr = 1; slv_low = 1'b0; rd_idx = 0;
      end else if (scl && p_scl && !p_sda && sda) begin
        stop_cnt++; in_xfer = 0; slv_low = 1'b0;
      end else if (in_xfer && scl && !p_scl) begin
        if (bitcnt < 8) shreg = {shreg[6:0], sda};
        else if (rd_mode && !is_addr) mack = !sda;
        bitcnt++;
      end else if (in_xfer && !scl && p_scl) begin
        if (bitcnt == 8) begin
          if (is_addr) begin
            addr_ok = (shreg[7:1] == SLV); rd_mode = shreg[0]; slv_low = addr_ok;
          end else if (!rd_mode && addr_ok) begin
            if (wr_cnt < 32) wr_log[wr_cnt] = shreg;
            slv_low = (wr_cnt != nack_at);
            wr_cnt++;
          end else slv_low = 1'b0;
        end else if (bitcnt == 9) begin
          bitcnt = 0;
          if (rd_mode && addr_ok && (is_addr || mack)) begin
            rd_byte = 8'hA0 + 8'(rd_idx); rd_idx++; slv_low = !rd_byte[7];
          end else slv_low = 1'b0;
          is_addr = 0;
        end else if (rd_mode && addr_ok && !is_addr && bitcnt >= 1 && bitcnt < 8)
          slv_low = !rd_byte[7-bitcnt];
      end
      if (scl) hi_run++;
      else begin
        if (p_scl) last_hi = hi_run;
        hi_run = 0;
      end
      p_scl = scl; p_sda = sda;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] w);
    tx_wr = 1'b1; tx_word = w;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] d);
    d = rx_data; rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic wait_bnb();
    int b0 = bnb_cnt;
    for (int i = 0; i < 8000 && bnb_cnt == b0; i++) @(negedge clk);
    repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int e0, s0, r0, b0, st0;
    repeat (3) @(negedge clk);
    // reset state (R6, R9)
    check("R6 reset tx_empty", tx_empty, 1);
    check("R6 reset rx_empty", rx_empty, 1);
    check("R6 reset tx_occ", tx_occ, 0);
    check("R9 reset busy", busy, 0);
    check("R9 reset lines", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // disabled: fill past full, nothing runs (R6, R10)
    for (int i = 0; i < 17; i++) push({2'b01, SLV, 1'b0});
    check("R6 tx_full", tx_full, 1);
    check("R6 tx_occ at 16", tx_occ, 15);
    repeat (100) @(negedge clk);
    check("R10 en low no start", start_cnt, 0);
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    check("R10 flush empties", tx_empty, 1);
    check("R10 flush occ", tx_occ, 0);
    en = 1'b1;

    for (int v = 0; v < 5; v++) begin
      logic rd; logic [6:0] ad; logic [7:0] ln, sd; int ee; string tg;
      rd = VEC[v][31]; ad = VEC[v][30:24]; ln = VEC[v][23:16];
      sd = VEC[v][15:8]; ee = int'(VEC[v][1:0]);
      tg = rd ? "R3" : (ln == 0 ? ((ad == SLV) ? "R4" : "R8") : "R2");
      e0 = err_cnt; s0 = stop_cnt; wr_cnt = 0;
      if (rd) begin
        push({2'b01, ad, 1'b1}); push({2'b10, ln});
      end else if (ln == 0) push({2'b11, ad, 1'b0});
      else begin
        push({2'b01, ad, 1'b0});
        for (int j = 0; j < int'(ln); j++) push({j == int'(ln) - 1, 1'b0, sd + 8'(j)});
      end
      wait_bnb();
      check({tg, " R1 address match"}, int'(addr_ok), int'(ad == SLV));
      check({tg, " R1 direction"}, int'(rd_mode), int'(rd));
      check({tg, " R9 stop count"}, stop_cnt - s0, 1);
      check({tg, " R9 busy clear"}, busy, 0);
      check({tg, " tx_err pulses"}, err_cnt - e0, ee);
      if (!rd && ad == SLV) begin
        check({tg, " bytes written"}, wr_cnt, int'(ln));
        for (int j = 0; j < int'(ln); j++) check({tg, " write data"}, wr_log[j], sd + 8'(j));
      end
      if (rd) begin
        check("R6 rx_occ", rx_occ, int'(ln) - 1);
        for (int j = 0; j < int'(ln); j++) begin
          pop_rx(d); check("R3 read data", d, 8'hA0 + 8'(j));
        end
        check("R3 rx drained", rx_empty, 1);
      end
    end
    check("R12 SCL high width", last_hi, DIV);

    // repeated start: write without stop, then read (R5)
    s0 = stop_cnt; r0 = rs_cnt; wr_cnt = 0;
    push({2'b01, SLV, 1'b0}); push({2'b00, 8'h5A});
    push({2'b01, SLV, 1'b1}); push({2'b10, 8'd2});
    wait_bnb();
    check("R5 repeated start", rs_cnt - r0, 1);
    check("R5 single stop", stop_cnt - s0, 1);
    check("R5 write byte", wr_log[0], 8'h5A);
    pop_rx(d); check("R5 read byte 0", d, 8'hA0);
    pop_rx(d); check("R5 read byte 1", d, 8'hA1);

    // receive threshold (R7)
    rx_lvl = 4'd2;
    push({2'b01, SLV, 1'b1}); push({2'b10, 8'd5});
    wait_bnb();
    check("R7 thr at 5", rx_thr, 1);
    check("R6 rx_occ 5", rx_occ, 4);
    pop_rx(d); pop_rx(d);
    check("R7 thr at 3", rx_thr, 1);
    pop_rx(d);
    check("R7 thr at 2", rx_thr, 0);
    pop_rx(d); pop_rx(d);
    rx_lvl = 4'd15;

    // count word late: SCL held low (R11)
    b0 = bnb_cnt;
    push({2'b01, SLV, 1'b1});
    repeat (300) @(negedge clk);
    check("R11 scl held low", scl_oe, 1);
    check("R11 still busy", busy, 1);
    check("R11 no stop", bnb_cnt - b0, 0);
    push({2'b10, 8'd2});
    wait_bnb();
    pop_rx(d); check("R11 read byte 0", d, 8'hA0);
    pop_rx(d); check("R11 read byte 1", d, 8'hA1);

    // NACK on second data byte; leftover word is discarded (R8, R13)
    nack_at = 1; wr_cnt = 0; e0 = err_cnt; s0 = stop_cnt;
    push({2'b01, SLV, 1'b0}); push({2'b00, 8'h01});
    push({2'b00, 8'h02}); push({2'b10, 8'h03});
    wait_bnb();
    check("R8 data nack stop", stop_cnt - s0, 1);
    check("R8 bytes before nack", wr_cnt, 2);
    check("R8 R13 err pulses", err_cnt - e0, 2);
    check("R8 queue drained", tx_empty, 1);
    nack_at = 99;

    // stray data word with bus free (R13)
    e0 = err_cnt; st0 = start_cnt;
    push({2'b00, 8'h33});
    repeat (50) @(negedge clk);
    check("R13 stray err", err_cnt - e0, 1);
    check("R13 no start", start_cnt - st0, 0);
    check("R13 bus free", busy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule